// File: doc/BRIEF.md
# External Bus Strobe Timing Controller

This block runs one access at a time on an external memory bus: it drives the address, a one-cycle address strobe, an active-low chip select, and active-low read and write strobes, all timed by the bus clock. Three configuration bits each add one clock cycle to the access:

- an address-delay bit, which adds an address setup cycle before chip select asserts and an address hold cycle after it negates;
- a setup bit, which adds a cycle between chip select assertion and the strobe;
- a hold bit, which adds a cycle between the strobe and chip select negation.

The setup and hold bits act independently of each other.

The internal side uses a request/acknowledge pair. The requester holds the request valid, together with the address, write data, direction and area number, until the acknowledge pulse. Acknowledge is high during the strobe cycle, and read data is valid from the next cycle on. If the requester presents its next request in the cycle right after the acknowledge and that request targets the same area, chip select stays low and the follow-on access runs without setup or hold cycles. Otherwise chip select negates through the normal hold path. The data bus appears as separate output, output-enable and input pins, for a pad ring that holds the tristate buffers.

Top module: `ebus_strobe_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select, read strobe and write strobe are high, the address strobe and acknowledge are low, and the data output enable is low.
- R2: Each accepted request produces exactly one address strobe pulse, one cycle long, in the first cycle of the access. That cycle carries the request's address, and the address does not change until the next address strobe.
- R3: For an access started from idle, chip select asserts 1 + S cycles before the read or write strobe asserts, where S is the setup bit.
- R4: Chip select negates 1 + H cycles after the read or write strobe negates, where H is the hold bit. When a same-area follow-on access is taken, this applies only after the last access.
- R5: With the address-delay bit at 1, chip select asserts one cycle after the address strobe cycle instead of within it. A request already waiting is not started until 2 cycles after chip select negates; with the bit at 0 this wait is 1 cycle.
- R6: A read drives the read strobe low for exactly one cycle. The value on the data input at the clock edge that ends that cycle appears on the read data output from the next cycle on.
- R7: A write drives the write strobe low for exactly one cycle. The write data is output with the output enable high from that cycle until chip select negates, or until the next address strobe if that comes first. At all other times the output enable is low.
- R8: When a request for the same area is valid in the cycle after an acknowledge, chip select stays low. The new address strobe follows 2 cycles after the previous strobe cycle, and its read or write strobe follows in the very next cycle, whatever the setup bit says.
- R9: When the request valid in the cycle after an acknowledge targets a different area, chip select negates through the hold path. The next access then starts from idle with its full address, setup and hold timing.
- R10: A request is taken only in the idle or chip-select-held cycle. The acknowledge pulses exactly once per access, in the strobe cycle, even though the requester keeps the request valid until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_addr_dly | input | 1 | Adds address setup and hold cycles around chip select |
| cfg_cs_setup | input | 1 | Adds a cycle from chip select to strobe |
| cfg_cs_hold | input | 1 | Adds a cycle from strobe to chip select negation |
| req_valid | input | 1 | Access request, held until acknowledge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_area | input | AREA_W | Chip select area of the request |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | Acknowledge, high in the strobe cycle |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_as | output | 1 | Address strobe, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DATA_W | Data bus output value |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_rdata | input | DATA_W | Data bus input value |

## Verification
The hardest situation to reach is the chip-select-held cycle, the single cycle in which a follow-on request can keep chip select low. The requester has to change its request in exactly the cycle after the acknowledge. The stimulus therefore waits for the acknowledge and presents the second request, for the same area or a different one, in the cycle right after it. This is done for every setting of the three configuration bits and for both orders of read and write. The strobe, chip select and address strobe times of both accesses are then compared with the cycle counts worked out from the bits.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  // Access sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // no access, chip select high
    ST_ADDR  = 3'd1,  // address strobe cycle
    ST_CSON  = 3'd2,  // chip select asserted after address setup
    ST_CSU   = 3'd3,  // extra chip select to strobe cycle
    ST_STB   = 3'd4,  // read or write strobe low
    ST_HELD  = 3'd5,  // chip select held, follow-on request may be taken
    ST_HOLD  = 3'd6,  // extra strobe to chip select cycle
    ST_AHOLD = 3'd7   // address hold after chip select negation
  } ebus_state_e;

  typedef struct packed {
    logic addr_dly;
    logic cs_setup;
    logic cs_hold;
  } ebus_cfg_t;

endpackage

// File: rtl/ebus_req_regs.sv
module ebus_req_regs
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  ebus_cfg_t         cfg_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              write_q,
  output logic [AREA_W-1:0] area_q,
  output ebus_cfg_t         cfg_q,
  output logic              area_hit
);

  // Request fields are captured whenever an access is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      area_q  <= '0;
    end else if (cap_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      area_q  <= req_area;
    end
  end

  // Timing bits are frozen for a whole chip select period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_in;
    end
  end

  assign area_hit = (req_area == area_q);

endmodule

// File: rtl/ebus_seq_fsm.sv
module ebus_seq_fsm
  import ebus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        area_hit,
  input  ebus_cfg_t   cfg_q,
  output ebus_state_e state_q,
  output logic        cont_q,
  output logic        accept,
  output logic        accept_new
);

  ebus_state_e state_d;

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    accept_new = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          accept_new = 1'b1;
          state_d    = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (cont_q)              state_d = ST_STB;
        else if (cfg_q.addr_dly) state_d = ST_CSON;
        else if (cfg_q.cs_setup) state_d = ST_CSU;
        else                     state_d = ST_STB;
      end
      ST_CSON:  state_d = cfg_q.cs_setup ? ST_CSU : ST_STB;
      ST_CSU:   state_d = ST_STB;
      ST_STB:   state_d = ST_HELD;
      ST_HELD: begin
        if (req_valid && area_hit) begin
          accept  = 1'b1;
          state_d = ST_ADDR;
        end else if (cfg_q.cs_hold) begin
          state_d = ST_HOLD;
        end else if (cfg_q.addr_dly) begin
          state_d = ST_AHOLD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HOLD:  state_d = cfg_q.addr_dly ? ST_AHOLD : ST_IDLE;
      ST_AHOLD: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Marks an access that continues an asserted chip select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
    end else if (accept) begin
      cont_q <= !accept_new;
    end
  end

endmodule

// File: rtl/ebus_pin_drv.sv
module ebus_pin_drv
  import ebus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ebus_state_e       state_q,
  input  logic              cont_q,
  input  ebus_cfg_t         cfg_q,
  input  logic              write_q,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              as_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              oe_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic cs_low;
  logic stb;
  logic wr_span;

  always_comb begin
    unique case (state_q)
      ST_ADDR:                          cs_low = cont_q || !cfg_q.addr_dly;
      ST_CSON, ST_CSU, ST_STB,
      ST_HELD, ST_HOLD:                 cs_low = 1'b1;
      default:                          cs_low = 1'b0;
    endcase
  end

  assign stb     = (state_q == ST_STB);
  assign wr_span = (state_q == ST_STB) || (state_q == ST_HELD) || (state_q == ST_HOLD);

  assign as_o   = (state_q == ST_ADDR);
  assign cs_n_o = !cs_low;
  assign rd_n_o = !(stb && !write_q);
  assign wr_n_o = !(stb && write_q);
  assign oe_o   = write_q && wr_span;
  assign ack_o  = stb;

  // Read data taken at the edge that ends the read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
    end else if (stb && !write_q) begin
      rd_data_o <= bus_rdata;
    end
  end

endmodule

// File: rtl/ebus_strobe_ctrl.sv
module ebus_strobe_ctrl
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_addr_dly,
  input  logic              cfg_cs_setup,
  input  logic              cfg_cs_hold,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_rdata
);

  ebus_cfg_t         cfg_in;
  ebus_cfg_t         cfg_q;
  ebus_state_e       state_q;
  logic              cont_q;
  logic              accept;
  logic              accept_new;
  logic              area_hit;
  logic              write_q;
  logic [AREA_W-1:0] area_q;

  assign cfg_in = '{addr_dly: cfg_addr_dly, cs_setup: cfg_cs_setup, cs_hold: cfg_cs_hold};

  ebus_req_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .AREA_W(AREA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (accept),
    .cfg_en    (accept_new),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_write (req_write),
    .req_area  (req_area),
    .cfg_in    (cfg_in),
    .addr_q    (bus_addr),
    .wdata_q   (bus_wdata),
    .write_q   (write_q),
    .area_q    (area_q),
    .cfg_q     (cfg_q),
    .area_hit  (area_hit)
  );

  ebus_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .area_hit   (area_hit),
    .cfg_q      (cfg_q),
    .state_q    (state_q),
    .cont_q     (cont_q),
    .accept     (accept),
    .accept_new (accept_new)
  );

  ebus_pin_drv #(
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cont_q    (cont_q),
    .cfg_q     (cfg_q),
    .write_q   (write_q),
    .bus_rdata (bus_rdata),
    .as_o      (bus_as),
    .cs_n_o    (bus_cs_n),
    .rd_n_o    (bus_rd_n),
    .wr_n_o    (bus_wr_n),
    .oe_o      (bus_data_oe),
    .ack_o     (req_ack),
    .rd_data_o (rd_data)
  );

endmodule

// File: rtl/ebus_strobe_chk.sv
module ebus_strobe_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_as,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_data_oe,
  input logic              req_ack,
  input logic [ADDR_W-1:0] bus_addr
);

  a_r2_as_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> !bus_as);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as && !bus_cs_n) |-> $stable(bus_addr));

  a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (!bus_cs_n && !bus_as));

  a_r4_cs_outlives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!bus_rd_n) || $past(!bus_wr_n)) |-> !bus_cs_n);

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |=> bus_rd_n);

  a_r7_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |=> bus_wr_n);

  a_r7_oe_only_writing: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (!bus_cs_n && bus_rd_n));

  a_r7_oe_starts_at_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe) |-> !bus_wr_n);

  a_r10_ack_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (bus_rd_n != bus_wr_n));

endmodule

bind ebus_strobe_ctrl ebus_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_as      (bus_as),
  .bus_cs_n    (bus_cs_n),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_data_oe (bus_data_oe),
  .req_ack     (req_ack),
  .bus_addr    (bus_addr)
);

// File: tb/sim_ebus_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_ebus_strobe_ctrl;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RW = 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_addr_dly, cfg_cs_setup, cfg_cs_hold;
  logic          req_valid, req_write;
  logic [RW-1:0] req_area;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ack;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic          bus_as, bus_cs_n, bus_rd_n, bus_wr_n, bus_data_oe;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;

  int n_chk, n_fail;
  bit done;

  // Memory model: read value is a fixed function of the address
  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  ebus_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_dly(cfg_addr_dly), .cfg_cs_setup(cfg_cs_setup), .cfg_cs_hold(cfg_cs_hold),
    .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_as(bus_as), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Event monitor, sampled mid-cycle
  int          cyc, n_as, n_csr, n_ack;
  int          t_as [2], t_csf [2], t_stb [2], t_csr [2];
  logic [AW-1:0] as_addr [2], stb_addr [2];
  logic [AW-1:0] exp_ad [2];
  logic [DW-1:0] exp_wd [2];
  logic        prev_cs_n;
  bit          wr_phase;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (bus_as || (!prev_cs_n && bus_cs_n)) wr_phase = 1'b0;
      if (bus_as && n_as < 2) begin
        t_as[n_as] = cyc; as_addr[n_as] = bus_addr; n_as++;
      end
      if (prev_cs_n && !bus_cs_n && n_as > 0) t_csf[n_as-1] = cyc;
      if ((!bus_rd_n || !bus_wr_n) && n_as > 0) begin
        t_stb[n_as-1] = cyc; stb_addr[n_as-1] = bus_addr;
      end
      if (!prev_cs_n && bus_cs_n && n_csr < 2) begin
        t_csr[n_csr] = cyc; n_csr++;
      end
      if (req_ack) n_ack++;
      if (!bus_wr_n) wr_phase = 1'b1;
      if (wr_phase && n_as > 0)
        check(bus_data_oe && bus_wdata == exp_wd[n_as-1], "R7 write data driven",
              {bus_data_oe, bus_wdata}, {1'b1, exp_wd[n_as-1]});
      else
        check(!bus_data_oe, "R7 output enable idle", bus_data_oe, 0);
      prev_cs_n = bus_cs_n;
    end
  end

  int seq;

  task automatic run(input bit a, input bit s, input bit h, input bit w0, input bit two,
                     input bit same, input bit w1);
    logic [RW-1:0] ar0;
    ar0 = RW'(seq % 7);
    @(negedge clk);
    n_as = 0; n_csr = 0; n_ack = 0;
    t_as = '{-99, -99}; t_csf = '{-99, -99}; t_stb = '{-99, -99}; t_csr = '{-99, -99};
    seq++;
    exp_ad[0] = 32'h1000_0000 + seq * 32'h44;
    exp_wd[0] = 32'hC0DE_0000 + seq;
    exp_ad[1] = exp_ad[0] + 32'h1_0004;
    exp_wd[1] = exp_wd[0] ^ 32'hFFFF_0000;
    cfg_addr_dly = a; cfg_cs_setup = s; cfg_cs_hold = h;
    req_valid = 1'b1; req_write = w0; req_area = ar0;
    req_addr = exp_ad[0]; req_wdata = exp_wd[0];
    do @(negedge clk); while (!req_ack);
    @(negedge clk);
    if (!w0) check(rd_data == mem_val(exp_ad[0]), "R6 read data", rd_data, mem_val(exp_ad[0]));
    if (two) begin
      req_write = w1; req_area = same ? ar0 : ar0 + 1'b1;
      req_addr = exp_ad[1]; req_wdata = exp_wd[1];
      do @(negedge clk); while (!req_ack);
      @(negedge clk);
      if (!w1) check(rd_data == mem_val(exp_ad[1]), "R6 read data second", rd_data,
                     mem_val(exp_ad[1]));
    end
    req_valid = 1'b0;
    repeat (8) @(negedge clk);

    check(n_as == 1 + two, "R2/R10 one address strobe per request", n_as, 1 + two);
    check(n_ack == 1 + two, "R10 one acknowledge per access", n_ack, 1 + two);
    check(as_addr[0] == exp_ad[0] && stb_addr[0] == exp_ad[0], "R2 address",
          as_addr[0], exp_ad[0]);
    check(t_csf[0] - t_as[0] == int'(a), "R5 address setup", t_csf[0] - t_as[0], a);
    check(t_stb[0] - t_csf[0] == 1 + s, "R3 setup", t_stb[0] - t_csf[0], 1 + s);
    if (!two) begin
      check(n_csr == 1, "R4 single chip select period", n_csr, 1);
      check(t_csr[0] - t_stb[0] == 2 + h, "R4 hold", t_csr[0] - t_stb[0], 2 + h);
    end else begin
      check(as_addr[1] == exp_ad[1] && stb_addr[1] == exp_ad[1], "R2 address second",
            as_addr[1], exp_ad[1]);
      if (same) begin
        check(n_csr == 1, "R8 chip select kept low", n_csr, 1);
        check(t_as[1] - t_stb[0] == 2, "R8 follow-on start", t_as[1] - t_stb[0], 2);
        check(t_stb[1] - t_as[1] == 1, "R8 no setup", t_stb[1] - t_as[1], 1);
        check(t_csr[0] - t_stb[1] == 2 + h, "R4 hold after last", t_csr[0] - t_stb[1], 2 + h);
      end else begin
        check(n_csr == 2, "R9 chip select reopened", n_csr, 2);
        check(t_csr[0] - t_stb[0] == 2 + h, "R9 hold applied", t_csr[0] - t_stb[0], 2 + h);
        check(t_as[1] - t_csr[0] == 1 + a, "R5 wait after negation", t_as[1] - t_csr[0], 1 + a);
        check(t_csf[1] - t_as[1] == int'(a), "R9 address setup", t_csf[1] - t_as[1], a);
        check(t_stb[1] - t_csf[1] == 1 + s, "R9 setup", t_stb[1] - t_csf[1], 1 + s);
        check(t_csr[1] - t_stb[1] == 2 + h, "R9 hold", t_csr[1] - t_stb[1], 2 + h);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; seq = 0; cyc = 0;
    prev_cs_n = 1'b1; wr_phase = 1'b0; n_as = 0; n_csr = 0; n_ack = 0;
    rst_n = 1'b0;
    cfg_addr_dly = 1'b0; cfg_cs_setup = 1'b0; cfg_cs_hold = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_area = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check({bus_cs_n, bus_rd_n, bus_wr_n, bus_as, req_ack, bus_data_oe} == 6'b111000,
          "R1 pins in reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_as, req_ack, bus_data_oe},
          6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    check({bus_cs_n, bus_rd_n, bus_wr_n, bus_as, req_ack, bus_data_oe} == 6'b111000,
          "R1 pins after reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_as, req_ack, bus_data_oe},
          6'b111000);
    for (int c = 0; c < 8; c++) begin
      for (int w = 0; w < 2; w++) begin
        run(c[2], c[1], c[0], w[0], 1'b0, 1'b0, 1'b0);
        run(c[2], c[1], c[0], w[0], 1'b1, 1'b1, !w[0]);
        run(c[2], c[1], c[0], w[0], 1'b1, 1'b0, !w[0]);
        run(c[2], c[1], c[0], w[0], 1'b1, 1'b1, w[0]);
      end
    end
    finish_run();
  end

endmodule